// File: doc/BRIEF.md
# Dual-Ratio Aligned Clock Divider

This block derives two banks of slower clocks from a single input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth of the input rate. Each bank has its own ratio select. Both banks decode one shared phase counter, so every edge that the two banks have in common falls on the same input rising edge. Each bank drives two identical registered copies of its clock.

An active-low run control is captured on the falling edge of the input clock. Stopping and restarting therefore always happen on whole input cycles, and the divided clocks never carry a shortened pulse. A synchronous active-low master reset puts all state into a fixed, aligned starting point, so that several instances released together stay in step. A change of ratio is applied only at a boundary that keeps the bank on the common phase grid.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With sel_a_i = 0 bank A divides the input clock by 2; with sel_a_i = 1 it divides by 4. The output is high for the first half of each period and low for the second half.
- R2: With sel_b_i = 0 bank B divides by 4 (2 cycles high, 2 low); with sel_b_i = 1 it divides by 6 (3 cycles high, 3 low).
- R3: On the first enabled rising edge after reset is released, both banks go high together. After that, counting enabled edges from k = 0, bank A is high when k mod N_A < N_A/2 and bank B is high when k mod N_B < N_B/2, so that common edges coincide.
- R4: rst_n_i is synchronous and active low. On every rising edge where it is sampled low, all outputs go to 0 and the phase restarts from k = 0.
- R5: en_n_i is active low and is sampled on the falling edge of clk_i. A change made just after a falling edge has no effect on the rising edge that follows. It takes effect on the rising edge after the next falling edge.
- R6: While the block is disabled, all outputs are 0 and the phase count holds its value. When the block is enabled again, the sequence resumes at the held phase.
- R7: Bank A applies a new select value only on an enabled edge where k is a multiple of 4. Bank B applies it only where k is a multiple of 12. The new ratio starts with its high half on that edge.
- R8: The two copies within each bank are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_n_i | input | 1 | Synchronous active-low master reset |
| en_n_i | input | 1 | Active-low run control, sampled on the falling edge |
| sel_a_i | input | 1 | Bank A ratio select: 0 = /2, 1 = /4 |
| sel_b_i | input | 1 | Bank B ratio select: 0 = /4, 1 = /6 |
| bank_a_o | output | COPIES (2) | Bank A divided clock copies |
| bank_b_o | output | COPIES (2) | Bank B divided clock copies |

## Verification
Outputs are registered, so each output level is due one rising edge after the phase and select values that produce it. A reset or select change driven 1 ns after a rising edge is visible 1 ns after the next rising edge. A run-control change is visible only on the first rising edge after a falling edge has captured it. The bench drives every input 1 ns after a rising edge, except in the falling-edge test, where it drives 1 ns after the falling edge. It samples 1 ns after each rising edge. It keeps an enabled-edge count k and the run state that the most recent falling edge would have captured, and it compares all four outputs on every cycle against levels computed from that count.

// File: rtl/clkdiv_pkg.sv
// Package: shared helpers for the dual-ratio divider.
// Assumes all ratios are even and positive.
package clkdiv_pkg;

    // Greatest common divisor, for deriving counter moduli at elaboration.
    function automatic int gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple of two ratios.
    function automatic int lcm(input int a, input int b);
        return (a / gcd(a, b)) * b;
    endfunction

    // Level of a 50% clock of period n at phase ph.
    function automatic logic half_high(input int ph, input int n);
        return (ph % n) < (n / 2);
    endfunction

endpackage

// File: rtl/cdiv_enable_sync.sv
// Module: run-control capture on the falling input edge.
// Because the captured value changes only while clk_i is low, the enabled
// rising edges are always whole input cycles. Reset is synchronous, active low.
module cdiv_enable_sync (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_n_i,
    output logic run_o
);

    // Capture the inverted active-low enable on the falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) begin
            run_o <= 1'b0;
        end else begin
            run_o <= ~en_n_i;
        end
    end

endmodule

// File: rtl/cdiv_phase_ctr.sv
// Module: shared phase counter, modulo MOD, that advances on enabled edges.
// Assumes MOD is a multiple of every ratio in use, so that all banks decode
// one common grid.
module cdiv_phase_ctr #(
    parameter int MOD = 12,
    localparam int PW = $clog2(MOD)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          run_i,
    output logic [PW-1:0] phase_o
);

    localparam logic [PW-1:0] LAST = PW'(MOD - 1);

    // Advance and wrap while running; hold while stopped.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            phase_o <= '0;
        end else if (run_i) begin
            phase_o <= (phase_o == LAST) ? '0 : phase_o + 1'b1;
        end
    end

endmodule

// File: rtl/cdiv_bank.sv
// Module: one bank of divided clocks with two selectable ratios.
// It decodes the shared phase and applies a new select only on phases that
// are multiples of SWITCH_EVERY, so a new ratio always starts on the grid.
// COPIES identical registered outputs are produced.
module cdiv_bank #(
    parameter int RATIO_LO     = 2,
    parameter int RATIO_HI     = 4,
    parameter int SWITCH_EVERY = 4,
    parameter int PW           = 4,
    parameter int COPIES       = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              run_i,
    input  logic [PW-1:0]     phase_i,
    input  logic              sel_i,
    output logic [COPIES-1:0] clk_o
);

    import clkdiv_pkg::*;

    logic hi_q;
    logic hi_eff;
    logic at_switch;
    logic level;

    // Decide which ratio applies on this edge.
    always_comb begin
        at_switch = (int'(phase_i) % SWITCH_EVERY) == 0;
        hi_eff    = at_switch ? sel_i : hi_q;
        level     = hi_eff ? half_high(int'(phase_i), RATIO_HI)
                           : half_high(int'(phase_i), RATIO_LO);
    end

    // Keep the ratio in force until the next switching point.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            hi_q <= 1'b0;
        end else if (run_i) begin
            hi_q <= hi_eff;
        end
    end

    // One output register per copy, low while stopped or in reset.
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                clk_o[c] <= 1'b0;
            end else begin
                clk_o[c] <= run_i & level;
            end
        end
    end

endmodule

// File: rtl/dual_ratio_clkdiv.sv
// Module: top of the dual-ratio aligned clock divider.
// Bank A divides by A_LO or A_HI, bank B by B_LO or B_HI, both from one
// shared phase counter whose modulus is the LCM of all ratios.
// The run control is retimed on the falling edge. Reset is synchronous, active low.
module dual_ratio_clkdiv #(
    parameter int A_LO   = 2,
    parameter int A_HI   = 4,
    parameter int B_LO   = 4,
    parameter int B_HI   = 6,
    parameter int COPIES = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              en_n_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    output logic [COPIES-1:0] bank_a_o,
    output logic [COPIES-1:0] bank_b_o
);

    import clkdiv_pkg::*;

    localparam int SW_A      = lcm(A_LO, A_HI);
    localparam int SW_B      = lcm(B_LO, B_HI);
    localparam int PHASE_MOD = lcm(SW_A, SW_B);
    localparam int PW        = $clog2(PHASE_MOD);

    logic          run_q;
    logic [PW-1:0] phase_q;

    cdiv_enable_sync u_en (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_n_i  (en_n_i),
        .run_o   (run_q)
    );

    cdiv_phase_ctr #(.MOD(PHASE_MOD)) u_phase (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (run_q),
        .phase_o (phase_q)
    );

    cdiv_bank #(
        .RATIO_LO(A_LO), .RATIO_HI(A_HI), .SWITCH_EVERY(SW_A),
        .PW(PW), .COPIES(COPIES)
    ) u_bank_a (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (run_q),
        .phase_i (phase_q),
        .sel_i   (sel_a_i),
        .clk_o   (bank_a_o)
    );

    cdiv_bank #(
        .RATIO_LO(B_LO), .RATIO_HI(B_HI), .SWITCH_EVERY(SW_B),
        .PW(PW), .COPIES(COPIES)
    ) u_bank_b (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (run_q),
        .phase_i (phase_q),
        .sel_i   (sel_b_i),
        .clk_o   (bank_b_o)
    );

endmodule

// File: rtl/cdiv_checker.sv
// Checker: temporal properties of the divider, bound into the top module.
module cdiv_checker #(
    parameter int PW     = 4,
    parameter int COPIES = 2
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              run_i,
    input logic [PW-1:0]     phase_i,
    input logic [COPIES-1:0] a_i,
    input logic [COPIES-1:0] b_i
);

    AST_COPIES_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (a_i == {COPIES{a_i[0]}}) && (b_i == {COPIES{b_i[0]}})); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> (a_i == '0) && (b_i == '0)); // R4

    AST_STOPPED_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !run_i |=> (a_i == '0) && (b_i == '0)); // R6

    AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rst_n_i && !run_i) |=> $stable(phase_i)); // R6

    AST_ALIGNED_START: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rst_n_i && run_i && phase_i == '0) |=> a_i[0] && b_i[0]); // R3

endmodule

bind dual_ratio_clkdiv cdiv_checker #(.PW(PW), .COPIES(COPIES)) u_chk (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .run_i   (run_q),
    .phase_i (phase_q),
    .a_i     (bank_a_o),
    .b_i     (bank_b_o)
);

// File: tb/dual_ratio_clkdiv_test.sv
module dual_ratio_clkdiv_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b0;
    logic       sel_a = 1'b0;
    logic       sel_b = 1'b0;
    logic [1:0] bank_a;
    logic [1:0] bank_b;

    int  tests  = 0;
    int  failed = 0;
    bit  done   = 1'b0;

    // Reference state, derived from the requirements.
    int  k      = 0;
    bit  en_nxt = 1'b0;
    bit  a_hi   = 1'b0;
    bit  b_hi   = 1'b0;

    // Stimulus table: {sel_a, sel_b, enabled cycles}.
    typedef struct packed {
        logic       sa;
        logic       sb;
        logic [7:0] n;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 8'd24},
        '{1'b1, 1'b0, 8'd24},
        '{1'b0, 1'b1, 8'd24},
        '{1'b1, 1'b1, 8'd36}
    };

    dual_ratio_clkdiv uut (
        .clk_i    (clk),
        .rst_n_i  (rst_n),
        .en_n_i   (en_n),
        .sel_a_i  (sel_a),
        .sel_b_i  (sel_b),
        .bank_a_o (bank_a),
        .bank_b_o (bank_b)
    );

    always #10 clk = ~clk;

    function automatic bit lvl(input int ph, input int n);
        return (ph % n) < (n / 2);
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: k=%0d got %b expected %b", req, k, got, exp);
        end
    endtask

    // Wait for one rising edge, update the reference, compare outputs.
    task automatic cycle(input string req);
        bit ea;
        bit eb;
        @(posedge clk);
        #1;
        ea = 1'b0;
        eb = 1'b0;
        if (!rst_n) begin
            k = 0; a_hi = 1'b0; b_hi = 1'b0;
        end else if (en_nxt) begin
            if (k % 4 == 0)  a_hi = sel_a;   // R7 bank A switching point
            if (k % 12 == 0) b_hi = sel_b;   // R7 bank B switching point
            ea = lvl(k, a_hi ? 4 : 2);
            eb = lvl(k, b_hi ? 6 : 4);
            k++;
        end
        check(req, {bank_a, bank_b}, {ea, ea, eb, eb});
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) cycle("R4 reset holds low");
        rst_n = 1'b1;
    endtask

    initial begin
        en_nxt = 1'b1;
        #1;
        // R4: outputs low while reset is held from time zero.
        do_reset(3);

        // Table walk: R1/R2 ratios and R3 alignment for each select pair.
        for (int v = 0; v < 4; v++) begin
            rst_n = 1'b0;
            sel_a = VECS[v].sa;
            sel_b = VECS[v].sb;
            cycle("R4 reset");
            rst_n = 1'b1;
            cycle("R3 first edge both high");
            check("R3 first edge both high", {bank_a, bank_b}, 4'b1111);
            for (int i = 1; i < int'(VECS[v].n); i++) cycle("R1/R2 ratio and duty");
        end

        // R4: reset mid-run forces low on the next edge.
        for (int i = 0; i < 5; i++) cycle("R2 run");
        rst_n = 1'b0;
        cycle("R4 mid-run reset");
        check("R4 mid-run reset", {bank_a, bank_b}, 4'b0000);
        rst_n = 1'b1;
        sel_a = 1'b0; sel_b = 1'b0;
        for (int i = 0; i < 7; i++) cycle("R3 restart");

        // R6: disable, hold low with frozen phase, then resume.
        en_n = 1'b1; en_nxt = 1'b0;
        for (int i = 0; i < 5; i++) cycle("R6 disabled low");
        en_n = 1'b0; en_nxt = 1'b1;
        for (int i = 0; i < 12; i++) cycle("R6 resume at held phase");

        // R5: change just after the falling edge is not seen on the next rise.
        @(negedge clk);
        #1;
        en_n = 1'b1;
        cycle("R5 still enabled after late change");
        en_nxt = 1'b0;
        cycle("R5 disabled after falling-edge capture");
        cycle("R5 disabled");
        @(negedge clk);
        #1;
        en_n = 1'b0;
        cycle("R5 still disabled after late change");
        en_nxt = 1'b1;
        for (int i = 0; i < 8; i++) cycle("R5 enabled after capture");

        // R7: select changes mid-run apply only at bank switching points.
        do_reset(1);
        sel_a = 1'b0; sel_b = 1'b0;
        for (int i = 0; i < 6; i++) cycle("R7 before change");
        sel_a = 1'b1; sel_b = 1'b1;
        for (int i = 0; i < 30; i++) cycle("R7 ratio switch on grid");
        sel_a = 1'b0; sel_b = 1'b0;
        for (int i = 0; i < 26; i++) cycle("R7 switch back");

        // R8: copies equal, checked on a running bank.
        check("R8 copies equal", {bank_a[0], bank_b[0]}, {bank_a[1], bank_b[1]});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #4000000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule